// File: doc/BRIEF.md
# Control-Byte Command/Data Router for an I2C Display Slave

This block sits behind the byte layer of an I2C slave. Its inputs are the bytes received from the bus together with pulses that mark a START or repeated START, a STOP, a read-byte request and the master's not-acknowledge. The first byte after any START is treated as the address byte. In a write transfer, the bytes that follow are split into control bytes and payload bytes. Two bits of each control byte set how the next bytes are handled. A continuation flag says whether a further control byte will come. A data/command flag sends each payload byte either to a command-decode strobe or to a display-RAM write port. The RAM write port has a self-advancing address pointer.

In a read transfer the block returns a status byte for each byte the master requests, and stops after the master's not-acknowledge. The data/command flag is kept across a repeated START, so a short write can select what a following read returns. The block also tracks high-speed mode. A master-code byte sent in fast/standard mode switches it on. Repeated STARTs leave it on. A STOP switches it off.

Top module: `cbyte_router`

## Requirements
- R1: After reset, no strobe or write enable is asserted, `hs_mode_o` is 0, `tx_byte_o` is 0x00, and the first display-RAM write goes to address 0.
- R2: The first byte after a START or repeated START is the address byte. Bits [7:1] are compared with `DEV_ADDR`, and bit 0 set to 1 requests a read. A match is acknowledged. On a mismatch, neither that byte nor any later byte is acknowledged or routed until the next START.
- R3: In a write, the byte after the address is a control byte and is acknowledged. Bit 7 is the continuation flag and bit 6 is the data/command flag. A continuation flag of 0 makes every later byte of the transfer a payload byte.
- R4: A control byte whose continuation flag is 1 is followed by exactly one payload byte, and the byte after that is again a control byte.
- R5: A payload byte received while the data/command flag is 0 is acknowledged and appears on `cmd_byte_o`, with `cmd_valid_o` high for one cycle in the cycle after the byte.
- R6: A payload byte received while the data/command flag is 1 is acknowledged and written to display RAM. `ram_we_o` is high for one cycle in the cycle after the byte, `ram_addr_o` carries the pointer value, and the pointer then increases by one.
- R7: After a write to the last address (`RAM_BYTES`-1), the pointer wraps to 0.
- R8: In a read, each `tx_req_i` pulse loads `tx_byte_o` with `status_i` when the data/command flag is 0, and with 0x00 when it is 1, because RAM read-back is not provided. Read bytes are never acknowledged by the block.
- R9: After `mnack_i`, further `tx_req_i` pulses leave `tx_byte_o` unchanged until a new read transfer begins.
- R10: The data/command flag set by the last control byte persists across a repeated START and decides what the next read returns.
- R11: An address-slot byte of the form 00001xxx received while `hs_mode_o` is 0 is a master code. It is not acknowledged and it sets `hs_mode_o`, which stays set across repeated STARTs.
- R12: A STOP clears `hs_mode_o` and ends the transfer. Bytes received after a STOP and before the next START are neither acknowledged nor routed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_i | input | 1 | STOP seen (one-cycle pulse) |
| rx_valid_i | input | 1 | Received byte valid (one-cycle pulse) |
| rx_byte_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge decision for the byte being presented (combinational) |
| tx_req_i | input | 1 | Master requests the next read byte |
| mnack_i | input | 1 | Master answered a read byte with not-acknowledge |
| status_i | input | 8 | Current device status |
| tx_byte_o | output | 8 | Byte to be shifted out on a read |
| cmd_valid_o | output | 1 | Command byte strobe |
| cmd_byte_o | output | 8 | Command byte |
| ram_we_o | output | 1 | Display-RAM write enable |
| ram_addr_o | output | $clog2(RAM_BYTES) | Display-RAM write address |
| ram_wdata_o | output | 8 | Display-RAM write data |
| hs_mode_o | output | 1 | High-speed mode active |

## Verification
The assertions assume that the byte layer never raises two of `start_i`, `stop_i`, `rx_valid_i`, `tx_req_i` and `mnack_i` in the same cycle, and that each is a single-cycle pulse. The bench drives one event per pulse task, separated by idle cycles, so these conditions always hold. Its random transfers mix write, read and mismatched-address transfers with optional master codes, repeated STARTs and STOPs. A reference model in the bench follows the pointer, the data/command flag and the high-speed state.

// File: rtl/cbyte_router.sv
module cbyte_router #(
  parameter logic [6:0] DEV_ADDR  = 7'h3C,
  parameter int         RAM_BYTES = 1280
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         stop_i,
  input  logic                         rx_valid_i,
  input  logic [7:0]                   rx_byte_i,
  output logic                         ack_o,
  input  logic                         tx_req_i,
  input  logic                         mnack_i,
  input  logic [7:0]                   status_i,
  output logic [7:0]                   tx_byte_o,
  output logic                         cmd_valid_o,
  output logic [7:0]                   cmd_byte_o,
  output logic                         ram_we_o,
  output logic [$clog2(RAM_BYTES)-1:0] ram_addr_o,
  output logic [7:0]                   ram_wdata_o,
  output logic                         hs_mode_o
);
  localparam int PW = $clog2(RAM_BYTES);
  localparam logic [PW-1:0] LAST = PW'(RAM_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CTRL, S_ONE, S_STRM, S_RD, S_IGN} st_t;

  st_t st_q;
  logic dc_q;
  logic [PW-1:0] ptr_q;

  wire take     = rx_valid_i && !start_i && !stop_i;
  wire is_mcode = !hs_mode_o && (rx_byte_i[7:3] == 5'b00001);
  wire addr_hit = rx_byte_i[7:1] == DEV_ADDR;
  wire in_pay   = (st_q == S_ONE) || (st_q == S_STRM);

  assign ack_o = take && ((st_q == S_ADDR && !is_mcode && addr_hit) ||
                          st_q == S_CTRL || in_pay);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      dc_q        <= 1'b0;
      ptr_q       <= '0;
      hs_mode_o   <= 1'b0;
      tx_byte_o   <= 8'h00;
      cmd_valid_o <= 1'b0;
      cmd_byte_o  <= 8'h00;
      ram_we_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_wdata_o <= 8'h00;
    end else begin
      cmd_valid_o <= 1'b0;
      ram_we_o    <= 1'b0;
      if (stop_i) begin
        st_q      <= S_IDLE;
        hs_mode_o <= 1'b0;
      end else if (start_i) begin
        st_q <= S_ADDR;
      end else if (take) begin
        case (st_q)
          S_ADDR: begin
            if (is_mcode) begin
              hs_mode_o <= 1'b1;
              st_q      <= S_IDLE;
            end else if (!addr_hit) st_q <= S_IGN;
            else st_q <= rx_byte_i[0] ? S_RD : S_CTRL;
          end
          S_CTRL: begin
            dc_q <= rx_byte_i[6];
            st_q <= rx_byte_i[7] ? S_ONE : S_STRM;
          end
          S_ONE, S_STRM: begin
            if (st_q == S_ONE) st_q <= S_CTRL;
            if (dc_q) begin
              ram_we_o    <= 1'b1;
              ram_addr_o  <= ptr_q;
              ram_wdata_o <= rx_byte_i;
              ptr_q       <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            end else begin
              cmd_valid_o <= 1'b1;
              cmd_byte_o  <= rx_byte_i;
            end
          end
          default: ;
        endcase
      end else if (st_q == S_RD) begin
        if (mnack_i) st_q <= S_IDLE;
        else if (tx_req_i) tx_byte_o <= dc_q ? 8'h00 : status_i;
      end
    end
  end

  p_one_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && ram_we_o));

  p_route_from_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o || ram_we_o) |-> $past(rx_valid_i));

  p_ptr_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (ptr_q == ((ram_addr_o == LAST) ? '0 : ram_addr_o + 1'b1)));

  p_hs_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_i) |-> !hs_mode_o);

  p_ignored_no_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IGN || st_q == S_IDLE || st_q == S_RD) |-> !ack_o);

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_q != S_RD) |-> $stable(tx_byte_o));
endmodule

// File: tb/cbyte_router_tb_top.sv
`timescale 1ns/1ps
module cbyte_router_tb_top;
  localparam logic [6:0] ADDR = 7'h3C;
  localparam int RAMB = 1280;
  localparam int PW = $clog2(RAMB);

  logic clk = 0, rst_n = 0;
  logic start_i = 0, stop_i = 0, rx_valid_i = 0, tx_req_i = 0, mnack_i = 0;
  logic [7:0] rx_byte_i = 0, status_i = 0;
  logic ack_o, cmd_valid_o, ram_we_o, hs_mode_o;
  logic [7:0] tx_byte_o, cmd_byte_o, ram_wdata_o;
  logic [PW-1:0] ram_addr_o;

  int nchk = 0, nerr = 0;
  int m_ptr = 0;
  bit m_dc = 0, m_hs = 0;

  always #2 clk = ~clk;

  cbyte_router #(.DEV_ADDR(ADDR), .RAM_BYTES(RAMB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .ack_o(ack_o),
    .tx_req_i(tx_req_i), .mnack_i(mnack_i), .status_i(status_i),
    .tx_byte_o(tx_byte_o), .cmd_valid_o(cmd_valid_o), .cmd_byte_o(cmd_byte_o),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .hs_mode_o(hs_mode_o));

  function automatic int next_ptr(int p);
    return (p == RAMB - 1) ? 0 : p + 1;
  endfunction

  function automatic logic [7:0] exp_tx(bit dc, logic [7:0] st);
    return dc ? 8'h00 : st;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
    m_hs = 0;
    chk(hs_mode_o == 1'b0, "R12 hs cleared by stop", hs_mode_o, 0);
  endtask

  task automatic read_byte(logic [7:0] st, logic [7:0] exp, string tag);
    @(negedge clk); status_i = st; tx_req_i = 1;
    @(negedge clk); tx_req_i = 0;
    chk(tx_byte_o == exp, tag, tx_byte_o, exp);
  endtask

  task automatic do_mnack();
    @(negedge clk); mnack_i = 1; @(negedge clk); mnack_i = 0;
  endtask

  // kind: 0 none, 1 command, 2 RAM
  task automatic send(logic [7:0] b, bit eack, int kind, string tag);
    @(negedge clk); rx_valid_i = 1; rx_byte_i = b;
    #1 chk(ack_o == eack, {tag, " ack"}, ack_o, eack);
    @(negedge clk); rx_valid_i = 0;
    chk(cmd_valid_o == (kind == 1), {tag, " cmd strobe"}, cmd_valid_o, kind == 1);
    chk(ram_we_o == (kind == 2), {tag, " ram strobe"}, ram_we_o, kind == 2);
    if (kind == 1) chk(cmd_byte_o == b, {tag, " cmd byte"}, cmd_byte_o, b);
    if (kind == 2) begin
      chk(int'(ram_addr_o) == m_ptr, {tag, " ram addr"}, ram_addr_o, m_ptr);
      chk(ram_wdata_o == b, {tag, " ram data"}, ram_wdata_o, b);
      m_ptr = next_ptr(m_ptr);
    end
  endtask

  task automatic payload(logic [7:0] b, string tag);
    send(b, 1, m_dc ? 2 : 1, m_dc ? {tag, " R6"} : {tag, " R5"});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hs_mode_o == 0, "R1 hs reset", hs_mode_o, 0);
    chk(tx_byte_o == 0, "R1 tx reset", tx_byte_o, 0);
    chk(!cmd_valid_o && !ram_we_o, "R1 strobes reset", cmd_valid_o, 0);

    // R1/R6: first RAM write lands at address 0
    do_start();
    send({ADDR, 1'b0}, 1, 0, "R2 addr");
    send(8'h40, 1, 0, "R3 ctrl");
    m_dc = 1;
    payload(8'hA5, "R1 first write");
    // R10: flag persists across repeated start
    do_start();
    send({ADDR, 1'b1}, 1, 0, "R2 addr rd");
    read_byte(8'h77, 8'h00, "R10 dc=1 read gives 0");
    do_start();
    send({ADDR, 1'b0}, 1, 0, "R2 addr");
    send(8'h00, 1, 0, "R3 ctrl");
    m_dc = 0;
    do_start();
    send({ADDR, 1'b1}, 1, 0, "R2 addr rd");
    send(8'h12, 0, 0, "R8 read slot byte ignored");
    read_byte(8'h5A, 8'h5A, "R10 dc=0 read gives status");
    do_mnack();
    read_byte(8'hC3, 8'h5A, "R9 hold after nack");
    do_stop();
    send(8'h3C, 0, 0, "R12 byte after stop");

    for (int t = 0; t < 250; t++) begin
      int kind;
      kind = $urandom_range(0, 9);
      do_start();
      if (!m_hs && $urandom_range(0, 3) == 0) begin
        send({5'b00001, 3'($urandom)}, 0, 0, "R11 master code");
        m_hs = 1;
        chk(hs_mode_o == 1, "R11 hs set", hs_mode_o, 1);
        do_start();
        chk(hs_mode_o == 1, "R11 hs kept on Sr", hs_mode_o, 1);
      end
      if (kind < 6) begin
        int nctl;
        nctl = $urandom_range(1, 4);
        send({ADDR, 1'b0}, 1, 0, "R2 addr wr");
        for (int c = 0; c < nctl; c++) begin
          bit co, dc;
          co = (c < nctl - 1);
          dc = 1'($urandom);
          send({co, dc, 6'($urandom)}, 1, 0, "R3 ctrl");
          m_dc = dc;
          if (co) payload(8'($urandom), "R4 single");
          else begin
            int np;
            np = $urandom_range(0, 5);
            for (int k = 0; k < np; k++) payload(8'($urandom), "R3 stream");
          end
        end
      end else if (kind < 8) begin
        int nr;
        logic [7:0] st;
        nr = $urandom_range(1, 3);
        send({ADDR, 1'b1}, 1, 0, "R2 addr rd");
        st = 0;
        for (int r = 0; r < nr; r++) begin
          st = 8'($urandom);
          read_byte(st, exp_tx(m_dc, st), "R8 read");
        end
        do_mnack();
        read_byte(~st, exp_tx(m_dc, st), "R9 after nack");
      end else begin
        send({ADDR ^ 7'h01, 1'b0}, 0, 0, "R2 mismatch");
        send(8'h00, 0, 0, "R2 ignored ctrl");
        send(8'($urandom), 0, 0, "R2 ignored byte");
      end
      if ($urandom_range(0, 1) == 1) begin
        do_stop();
        send(8'($urandom), 0, 0, "R12 idle byte");
      end
    end

    // R7: stream across the end of RAM
    do_start();
    send({ADDR, 1'b0}, 1, 0, "R2 addr wr");
    send(8'h40, 1, 0, "R3 ctrl");
    m_dc = 1;
    begin
      int n;
      n = RAMB - m_ptr + 2;
      for (int k = 0; k < n; k++) payload(8'($urandom), "R7 wrap");
    end
    chk(m_ptr == 2, "R7 model wrapped", m_ptr, 2);
    do_stop();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule